// File: doc/BRIEF.md
# I/O Window Base Register and Cycle Decoder

This block holds the 32-bit configuration-space register that places a small I/O window for one device function, and decides for each host I/O cycle whether the function claims it. Software programs a base field that is aligned at bit 6 of a 16-bit I/O address. Only the first eight bytes starting at that base are decoded.

A hide control can remove the register from software's view. While it is set, the register reads as all zeros, ignores writes and claims nothing. Claims are also gated by four sideband conditions:

- the power state must be D0;
- the command-register I/O enable must be set;
- the function must be present;
- internal graphics must be enabled.

A claim is produced one clock after the request and does not depend on any VGA decode state.

Top module: `ioWindowBar`

## Requirements
- R1: After reset the register reads 0x00000001, with the base field at zero.
- R2: A configuration write while not hidden stores write-data bits 15:6 as the base field. The readback is then (base << 6) | 1, and every other written bit is ignored.
- R3: While not hidden, read bits 2:1 are always 0 and read bit 0 is always 1.
- R4: Read bits 31:16 and 5:3 are always 0.
- R5: While the hide input is 1, the whole register reads 0x00000000.
- R6: Writes made while the hide input is 1 leave the stored base unchanged. This is observed by reading back after the hide input is cleared.
- R7: A request is claimed only when all of the following hold:
  - pwrState is 2'b00 (D0), where 2'b01, 2'b10 and 2'b11 are D1, D2 and D3;
  - ioEnable is 1;
  - devPresent is 1;
  - gfxEnable is 1;
  - hide is 0.
- R8: The size code is ioSize 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes; code 3 is never claimed. A request hits when all of the following hold:
  - ioAddr[15:6] equals the base field;
  - ioAddr[5:3] is zero;
  - ioAddr[2:0] plus the byte count is at most 8. Accesses that cross the end of the window are not claimed.
- R9: ioClaim is registered. It is high in the cycle after a valid request that is allowed and hits, and it is low in the cycle after any cycle with ioValid low.
- R10: When a configuration write and an I/O request fall in the same cycle, the request is decoded against the base held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe for the register |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Current register read value |
| pwrState | input | 2 | Power state, 0 = D0, 1..3 = D1..D3 |
| ioEnable | input | 1 | I/O enable bit of the command register |
| devPresent | input | 1 | Function is turned on |
| gfxEnable | input | 1 | Internal graphics enabled |
| barHide | input | 1 | Hides the register and blocks claims |
| ioValid | input | 1 | I/O request valid |
| ioAddr | input | 16 | I/O request address |
| ioSize | input | 2 | Request size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) |
| ioClaim | output | 1 | Registered claim of the previous request |

## Verification
A configuration write that moves the base can land in the same cycle as an I/O request aimed at the old window. The bench drives both on one edge, with the request inside the old window and the new base elsewhere. It expects a claim on the next cycle, because the request is decoded against the old base. A later request at the new base must also be claimed. The rest of the bench sweeps addresses around several bases with every size code, and walks all combinations of the gating inputs, with the expected claim worked out arithmetically.

// File: rtl/ioWindowBarPkg.sv
package ioWindowBarPkg;
  typedef enum logic [1:0] {
    PWR_D0 = 2'd0,
    PWR_D1 = 2'd1,
    PWR_D2 = 2'd2,
    PWR_D3 = 2'd3
  } pwrStateT;

  typedef struct packed {
    logic baseWe;
    logic decodeEn;
  } barStrobeT;
endpackage

// File: rtl/ioWindowBarCtrl.sv
module ioWindowBarCtrl
  import ioWindowBarPkg::*;
(
  input  logic       cfgWrEn,
  input  logic [1:0] pwrState,
  input  logic       ioEnable,
  input  logic       devPresent,
  input  logic       gfxEnable,
  input  logic       barHide,
  input  logic       ioValid,
  output barStrobeT  strobes
);
  logic accessOk;

  always_comb begin
    accessOk = (pwrState == PWR_D0) && ioEnable && devPresent && gfxEnable && !barHide;
    strobes.baseWe   = cfgWrEn && !barHide;
    strobes.decodeEn = ioValid && accessOk;
  end
endmodule

// File: rtl/ioWindowBarDatapath.sv
module ioWindowBarDatapath
  import ioWindowBarPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 6,
  parameter int WIN_LOG2 = 3,
  parameter int REG_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  barStrobeT                  strobes,
  input  logic [ADDR_W-BASE_LSB-1:0] wrBase,
  input  logic                       barHide,
  input  logic                       ioValid,
  input  logic [ADDR_W-1:0]          ioAddr,
  input  logic [1:0]                 ioSize,
  output logic [REG_W-1:0]           cfgRdData,
  output logic                       ioClaim
);
  localparam int BASE_W = ADDR_W - BASE_LSB;
  localparam int CNT_W  = WIN_LOG2 + 2;
  localparam logic [CNT_W-1:0] WIN_BYTES = CNT_W'(1 << WIN_LOG2);

  logic [BASE_W-1:0] baseQ;
  logic              claimQ;
  logic [CNT_W-1:0]  byteCnt;
  logic [CNT_W-1:0]  endOff;
  logic              baseMatch;
  logic              gapZero;
  logic              hit;

  always_ff @(posedge clk) begin
    if (!rstN)               baseQ <= '0;
    else if (strobes.baseWe) baseQ <= wrBase;
  end

  always_comb begin
    cfgRdData = '0;
    if (!barHide) begin
      cfgRdData[ADDR_W-1:BASE_LSB] = baseQ;
      cfgRdData[0] = 1'b1;
    end
  end

  always_comb begin
    case (ioSize)
      2'd0:    byteCnt = CNT_W'(1);
      2'd1:    byteCnt = CNT_W'(2);
      2'd2:    byteCnt = CNT_W'(4);
      default: byteCnt = '0;
    endcase
    endOff    = CNT_W'(ioAddr[WIN_LOG2-1:0]) + byteCnt;
    baseMatch = (ioAddr[ADDR_W-1:BASE_LSB] == baseQ);
    gapZero   = (ioAddr[BASE_LSB-1:WIN_LOG2] == '0);
    hit       = baseMatch && gapZero && (byteCnt != '0) && (endOff <= WIN_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rstN) claimQ <= 1'b0;
    else       claimQ <= strobes.decodeEn && hit;
  end

  assign ioClaim = claimQ;

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strobes.baseWe |=> $stable(baseQ)); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN) (cfgRdData[REG_W-1:ADDR_W] == '0) && (cfgRdData[BASE_LSB-1:1] == '0)); // R4
  AST_HIDE_ZERO: assert property (@(posedge clk) disable iff (!rstN) barHide |-> (cfgRdData == '0)); // R5
  AST_CLAIM_ALIGNED: assert property (@(posedge clk) disable iff (!rstN) ioClaim |-> ($past(ioAddr[BASE_LSB-1:WIN_LOG2]) == '0)); // R8
  AST_CLAIM_SIZE: assert property (@(posedge clk) disable iff (!rstN) ioClaim |-> ($past(ioSize) != 2'd3)); // R8
  AST_CLAIM_REQ: assert property (@(posedge clk) disable iff (!rstN) ioClaim |-> $past(ioValid)); // R9
endmodule

// File: rtl/ioWindowBar.sv
module ioWindowBar
  import ioWindowBarPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 6,
  parameter int WIN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic [1:0]        pwrState,
  input  logic              ioEnable,
  input  logic              devPresent,
  input  logic              gfxEnable,
  input  logic              barHide,
  input  logic              ioValid,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  output logic              ioClaim
);
  barStrobeT strobes;
  logic      unusedWrBits;

  assign unusedWrBits = ^{cfgWrData[31:ADDR_W], cfgWrData[BASE_LSB-1:0]};

  ioWindowBarCtrl u_ctrl (
    .cfgWrEn    (cfgWrEn),
    .pwrState   (pwrState),
    .ioEnable   (ioEnable),
    .devPresent (devPresent),
    .gfxEnable  (gfxEnable),
    .barHide    (barHide),
    .ioValid    (ioValid),
    .strobes    (strobes)
  );

  ioWindowBarDatapath #(
    .ADDR_W   (ADDR_W),
    .BASE_LSB (BASE_LSB),
    .WIN_LOG2 (WIN_LOG2),
    .REG_W    (32)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrBase    (cfgWrData[ADDR_W-1:BASE_LSB]),
    .barHide   (barHide),
    .ioValid   (ioValid),
    .ioAddr    (ioAddr),
    .ioSize    (ioSize),
    .cfgRdData (cfgRdData),
    .ioClaim   (ioClaim)
  );

  AST_GATED_NO_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    !((pwrState == PWR_D0) && ioEnable && devPresent && gfxEnable && !barHide) |=> !ioClaim); // R7
  AST_IDLE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rstN) !ioValid |=> !ioClaim); // R9
endmodule

// File: tb/ioWindowBar_tb.sv
module ioWindowBar_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [1:0]  pwrState = 2'd0;
  logic        ioEnable = 1'b1;
  logic        devPresent = 1'b1;
  logic        gfxEnable = 1'b1;
  logic        barHide = 1'b0;
  logic        ioValid = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic        ioClaim;

  int total = 0;
  int bad = 0;
  logic [9:0] curBase = '0;

  always #4 clk = ~clk;

  ioWindowBar u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .pwrState(pwrState), .ioEnable(ioEnable), .devPresent(devPresent), .gfxEnable(gfxEnable),
    .barHide(barHide), .ioValid(ioValid), .ioAddr(ioAddr), .ioSize(ioSize), .ioClaim(ioClaim)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic expHit(input logic [15:0] a, input logic [1:0] s, input logic [9:0] b);
    int n;
    n = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
    return (a[15:6] == b) && (a[5:3] == 3'd0) && (n != 0) && ((int'(a[2:0]) + n) <= 8);
  endfunction

  function automatic logic expAllow(input logic [1:0] p, input logic e, input logic d, input logic g, input logic h);
    return (p == 2'd0) && e && d && g && !h;
  endfunction

  task automatic request(input logic [15:0] a, input logic [1:0] s, input logic exp, input string req);
    @(negedge clk);
    ioValid = 1'b1;
    ioAddr = a;
    ioSize = s;
    @(negedge clk);
    ioValid = 1'b0;
    check(ioClaim == exp, req, {31'd0, ioClaim}, {31'd0, exp});
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] bases [4];
    bases[0] = 10'h000;
    bases[1] = 10'h007;
    bases[2] = 10'h155;
    bases[3] = 10'h3FF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset value
    check(cfgRdData == 32'h1, "R1", cfgRdData, 32'h1);
    check(ioClaim == 1'b0, "R1", {31'd0, ioClaim}, 32'd0);

    // R2 / R3 / R4: write with all bits set; only bits 15:6 are kept
    cfgWrite(32'hFFFF_FFFF);
    @(negedge clk);
    check(cfgRdData == 32'h0000_FFC1, "R2", cfgRdData, 32'h0000_FFC1);
    check(cfgRdData[2:0] == 3'b001, "R3", cfgRdData, 32'h1);
    check(cfgRdData[31:16] == 0 && cfgRdData[5:3] == 0, "R4", cfgRdData, 32'h0000_FFC1);

    // R5 hidden read and R6 writes blocked
    barHide = 1'b1;
    @(negedge clk);
    check(cfgRdData == 32'h0, "R5", cfgRdData, 32'h0);
    cfgWrite(32'h0000_1240);
    @(negedge clk);
    check(cfgRdData == 32'h0, "R5", cfgRdData, 32'h0);
    barHide = 1'b0;
    @(negedge clk);
    check(cfgRdData == 32'h0000_FFC1, "R6", cfgRdData, 32'h0000_FFC1);

    // R8 sweep around several bases, every size code
    foreach (bases[i]) begin
      curBase = bases[i];
      cfgWrite({16'h0, curBase, 6'h3F});
      @(negedge clk);
      check(cfgRdData == {16'h0, curBase, 6'h01}, "R2", cfgRdData, {16'h0, curBase, 6'h01});
      for (int off = -64; off < 128; off++) begin
        for (int s = 0; s < 4; s++) begin
          logic [15:0] a;
          a = 16'(int'({curBase, 6'h0}) + off);
          request(a, 2'(s), expHit(a, 2'(s), curBase), "R8");
        end
      end
    end

    // R7 gating combinations; the window is at base 0x3FF
    for (int g = 0; g < 64; g++) begin
      pwrState = g[1:0];
      ioEnable = g[2];
      devPresent = g[3];
      gfxEnable = g[4];
      barHide = g[5];
      request(16'hFFC0, 2'd2, expAllow(g[1:0], g[2], g[3], g[4], g[5]), "R7");
    end
    pwrState = 2'd0; ioEnable = 1'b1; devPresent = 1'b1; gfxEnable = 1'b1; barHide = 1'b0;

    // R9 claim drops when no request; a held request claims every cycle
    @(negedge clk);
    ioValid = 1'b1; ioAddr = 16'hFFC4; ioSize = 2'd1;
    @(negedge clk);
    check(ioClaim == 1'b1, "R9", {31'd0, ioClaim}, 32'd1);
    @(negedge clk);
    check(ioClaim == 1'b1, "R9", {31'd0, ioClaim}, 32'd1);
    ioValid = 1'b0;
    @(negedge clk);
    check(ioClaim == 1'b0, "R9", {31'd0, ioClaim}, 32'd0);

    // R10 write and request in one cycle: decode uses the old base 0x3FF
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 32'h0000_0440;
    ioValid = 1'b1; ioAddr = 16'hFFC0; ioSize = 2'd0;
    @(negedge clk);
    cfgWrEn = 1'b0; ioValid = 1'b0;
    check(ioClaim == 1'b1, "R10", {31'd0, ioClaim}, 32'd1);
    request(16'h0440, 2'd2, 1'b1, "R10");
    request(16'hFFC0, 2'd0, 1'b0, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule